// File: doc/BRIEF.md
# Serial-Loaded Memory Bank Controller

This block sits on the cartridge side of an 8-bit CPU system. It turns a stream of single-bit CPU writes into bank numbers for program and pattern memory. Each accepted write contributes one data bit to a five-bit shift latch, filled from the least significant bit. The fifth bit completes a word, and that word is stored in one of four internal registers: mode, pattern bank A, pattern bank B or program bank. The target register is chosen by address bits 14:13 at the moment of the fifth write. A write with data bit 7 set abandons any partial word and forces the mode register into its default program layout.

From these registers the block drives three sets of outputs. It gives four 8 KiB program page numbers, one for each slot of the 32 KiB CPU window. It gives eight 1 KiB pattern page numbers, one for each slot of the 8 KiB pattern space. It also gives a two-bit nametable mirroring code. ROM sizes are parameters given as page counts, which must be powers of two. Every bank number wraps modulo the page count.

The write port has no back-pressure. It accepts a write in every cycle in which `wr_en` is high, so there is no ready signal and no write is ever refused. The page outputs are registered, and they change only on the clock edge after the edge that samples the fifth write of a word.

Top module: `serial_bank_ctrl`

## Requirements
- R1: After reset the program pages read 0, 1, PRG_PAGES-2, PRG_PAGES-1 for slots 0..3. The pattern pages read 0..7 for slots 0..7, and `mirror` reads 3.
- R2: A write with `wr_d7`=1 discards the partial word and the bit count, and sets mode bits 3 and 2. It causes no output update by itself.
- R3: Writes with `wr_d7`=0 shift in `wr_d0` least significant bit first. The fifth such write stores the word into the register picked by `wr_sel`: 0 is mode, 1 is pattern bank A, 2 is pattern bank B and 3 is program bank.
- R4: The program bank register keeps only the low 4 bits of the word.
- R5: `mirror` equals mode bits 1:0 XOR 3.
- R6: With mode bit 3 clear, slots 0..3 hold four consecutive pages starting at program bank × 4.
- R7: With mode bits 3 and 2 both set, slots 0..1 hold program bank × 2 and the page after it. Slots 2..3 hold the last two pages.
- R8: With mode bit 3 set and bit 2 clear, slots 0..1 hold pages 0 and 1. Slots 2..3 hold program bank × 2 and the page after it.
- R9: With mode bit 4 set, pattern slots 0..3 are bank A × 4 + 0..3 and slots 4..7 are bank B × 4 + 0..3.
- R10: With mode bit 4 clear, pattern slots 0..7 are (bank A with bit 0 cleared) × 4 + 0..7.
- R11: Every page number wraps modulo its page count.
- R12: When PRG_PAGES is 64, pattern bank A bit 4 adds 32 to the switchable program base. With 32 pages it has no effect on program pages.
- R13: Outputs change only on the clock edge after the edge that samples a fifth write. They hold otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one bit accepted per cycle it is high |
| wr_sel | input | 2 | CPU address bits 14:13 for the write |
| wr_d7 | input | 1 | Data bit 7: clear request |
| wr_d0 | input | 1 | Data bit 0: serial bit |
| prg_pages | output | 4*PW | Program page per 8 KiB slot, slot 0 in the low bits |
| chr_pages | output | 8*CW | Pattern page per 1 KiB slot, slot 0 in the low bits |
| mirror | output | 2 | Nametable mirroring code |

## Verification
The bench aborts a word partway through with a clear write and then completes a new word. A design that kept the stale latch bits or the old count would then store a wrong program bank and show the wrong pages. It checks that a 5-bit value sent to the program bank shows its effect only through the low 4 bits, on a 64-page instance where a fifth bit would move the page. It drives 32K-mode bank numbers past the end of ROM so that a design without wrap would leave the ROM. It samples between the write edge and the update edge, where an early or late update shows as the wrong pages. A second instance with 64 program pages checks the half-select, which a 32-page design must ignore.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int WORD_BITS = 5;
  typedef struct packed {
    logic [4:0] mode;
    logic [4:0] chr_a;
    logic [4:0] chr_b;
    logic [3:0] prg;
  } bank_regs_t;
endpackage

// File: rtl/sbc_shift_loader.sv
module sbc_shift_loader #(
  parameter int WB = sbc_pkg::WORD_BITS,
  localparam int NW = $clog2(WB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          bit_clear,
  input  logic          bit_in,
  output logic          clr_pulse,
  output logic          word_done,
  output logic [WB-1:0] word
);
  logic [NW-1:0] cnt;
  logic [WB-2:0] latch;

  always_comb begin
    clr_pulse = wr_en & bit_clear;
    word_done = wr_en & ~bit_clear & (cnt == NW'(WB - 1));
    word      = {bit_in, latch};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_pulse || word_done) begin
      cnt   <= '0;
      latch <= '0;
    end else if (wr_en) begin
      latch <= latch | ((WB-1)'(bit_in) << cnt);
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sbc_bank_regs.sv
module sbc_bank_regs
  import sbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_pulse,
  input  logic       word_done,
  input  logic [1:0] sel,
  input  logic [4:0] word,
  output bank_regs_t regs
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (clr_pulse) begin
      regs.mode <= regs.mode | 5'h0C;
    end else if (word_done) begin
      case (sel)
        2'd0:    regs.mode  <= word;
        2'd1:    regs.chr_a <= word;
        2'd2:    regs.chr_b <= word;
        default: regs.prg   <= word[3:0];
      endcase
    end
  end
endmodule

// File: rtl/sbc_page_map.sv
module sbc_page_map
  import sbc_pkg::*;
#(
  parameter int PRG_PAGES = 32,
  parameter int CHR_PAGES = 128,
  localparam int PW = $clog2(PRG_PAGES),
  localparam int CW = $clog2(CHR_PAGES)
) (
  input  bank_regs_t      regs,
  output logic [4*PW-1:0] prg_flat,
  output logic [8*CW-1:0] chr_flat,
  output logic [1:0]      mirror
);
  logic [PW-1:0] half_off, b32, b16;
  logic [CW-1:0] c_lo, c_hi, c8;

  generate
    if (PRG_PAGES == 64) begin : g_half
      assign half_off = regs.chr_a[4] ? PW'(32) : '0;
    end else begin : g_nohalf
      assign half_off = '0;
    end
  endgenerate

  always_comb begin
    b32 = PW'({regs.prg, 2'b00}) + half_off;
    b16 = PW'({regs.prg, 1'b0}) + half_off;
    if (!regs.mode[3]) begin
      prg_flat = {b32 + PW'(3), b32 + PW'(2), b32 + PW'(1), b32};
    end else if (regs.mode[2]) begin
      prg_flat = {PW'(PRG_PAGES - 1), PW'(PRG_PAGES - 2), b16 + PW'(1), b16};
    end else begin
      prg_flat = {b16 + PW'(1), b16, PW'(1), PW'(0)};
    end
    mirror = regs.mode[1:0] ^ 2'b11;
    c_lo   = CW'({regs.chr_a, 2'b00});
    c_hi   = CW'({regs.chr_b, 2'b00});
    c8     = CW'({regs.chr_a[4:1], 3'b000});
  end

  for (genvar i = 0; i < 8; i++) begin : g_chr
    assign chr_flat[i*CW +: CW] = regs.mode[4]
      ? (((i < 4) ? c_lo : c_hi) + CW'(i % 4))
      : (c8 + CW'(i));
  end
endmodule

// File: rtl/serial_bank_ctrl.sv
module serial_bank_ctrl
  import sbc_pkg::*;
#(
  parameter int PRG_PAGES = 32,
  parameter int CHR_PAGES = 128,
  localparam int PW = $clog2(PRG_PAGES),
  localparam int CW = $clog2(CHR_PAGES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic            wr_d7,
  input  logic            wr_d0,
  output logic [4*PW-1:0] prg_pages,
  output logic [8*CW-1:0] chr_pages,
  output logic [1:0]      mirror
);
  logic            clr_pulse, word_done, upd_q;
  logic [4:0]      word;
  bank_regs_t      regs;
  logic [4*PW-1:0] prg_next;
  logic [8*CW-1:0] chr_next;
  logic [1:0]      mir_next;

  sbc_shift_loader #(.WB(WORD_BITS)) u_load (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bit_clear(wr_d7),
    .bit_in(wr_d0), .clr_pulse(clr_pulse), .word_done(word_done), .word(word)
  );

  sbc_bank_regs u_regs (
    .clk(clk), .rst_n(rst_n), .clr_pulse(clr_pulse), .word_done(word_done),
    .sel(wr_sel), .word(word), .regs(regs)
  );

  sbc_page_map #(.PRG_PAGES(PRG_PAGES), .CHR_PAGES(CHR_PAGES)) u_map (
    .regs(regs), .prg_flat(prg_next), .chr_flat(chr_next), .mirror(mir_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_q     <= 1'b0;
      prg_pages <= {PW'(PRG_PAGES - 1), PW'(PRG_PAGES - 2), PW'(1), PW'(0)};
      for (int i = 0; i < 8; i++) chr_pages[i*CW +: CW] <= CW'(i);
      mirror    <= 2'b11;
    end else begin
      upd_q <= word_done;
      if (upd_q) begin
        prg_pages <= prg_next;
        chr_pages <= chr_next;
        mirror    <= mir_next;
      end
    end
  end
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int PRG_PAGES = 32,
  parameter int CHR_PAGES = 128,
  localparam int PW = $clog2(PRG_PAGES),
  localparam int CW = $clog2(CHR_PAGES)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            upd_q,
  input logic            clr_pulse,
  input logic [4:0]      mode,
  input logic [4*PW-1:0] prg_pages,
  input logic [8*CW-1:0] chr_pages,
  input logic [1:0]      mirror
);
  p_hold_outputs_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_q |=> $stable(prg_pages) && $stable(chr_pages) && $stable(mirror));

  p_clear_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> mode[3:2] == 2'b11);

  p_mirror_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> mirror == ($past(mode[1:0]) ^ 2'b11));

  p_fixed_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q && mode[3] && mode[2] |=> prg_pages[4*PW-1 -: PW] == PW'(PRG_PAGES - 1));

  p_fixed_bottom_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q && mode[3] && !mode[2] |=> prg_pages[PW-1:0] == '0);

  p_chr_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q && !mode[4] |=> chr_pages[2*CW-1 -: CW] == CW'(chr_pages[CW-1:0] + 1'b1));
endmodule

bind serial_bank_ctrl sbc_checker #(.PRG_PAGES(PRG_PAGES), .CHR_PAGES(CHR_PAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_q(upd_q), .clr_pulse(clr_pulse),
  .mode(regs.mode), .prg_pages(prg_pages), .chr_pages(chr_pages), .mirror(mirror)
);

// File: tb/tb_serial_bank_ctrl.sv
module tb_serial_bank_ctrl;
  localparam int PW = 5, PWB = 6, CW = 7;
  logic clk = 0, rst_n = 0, wr_en = 0, wr_d7 = 0, wr_d0 = 0;
  logic [1:0] wr_sel = '0;
  logic [4*PW-1:0]  prg_s;
  logic [4*PWB-1:0] prg_b;
  logic [8*CW-1:0]  chr_s, chr_b;
  logic [1:0]       mir_s, mir_b;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_bank_ctrl dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_d7(wr_d7), .wr_d0(wr_d0), .prg_pages(prg_s), .chr_pages(chr_s), .mirror(mir_s));

  serial_bank_ctrl #(.PRG_PAGES(64)) dut_big (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_d7(wr_d7), .wr_d0(wr_d0), .prg_pages(prg_b),
    .chr_pages(chr_b), .mirror(mir_b));

  function automatic logic [63:0] pk4(input int p0, p1, p2, p3, input int w);
    logic [63:0] m = (64'd1 << w) - 1;
    return (64'(p0) & m) | ((64'(p1) & m) << w) | ((64'(p2) & m) << 2*w) |
           ((64'(p3) & m) << 3*w);
  endfunction

  function automatic logic [63:0] pkc(input int lo, hi);
    logic [63:0] r = 0;
    for (int i = 0; i < 4; i++) begin
      r |= (64'(lo + i) & 64'h7F) << (i * CW);
      r |= (64'(hi + i) & 64'h7F) << ((i + 4) * CW);
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic d7, d0);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_d7 = d7; wr_d0 = d0;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic load(input logic [1:0] s, input logic [4:0] v);
    for (int i = 0; i < 5; i++) wr(s, 1'b0, v[i]);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 prg", 64'(prg_s), pk4(0, 1, 30, 31, PW));
    chk("R1 prg big", 64'(prg_b), pk4(0, 1, 62, 63, PWB));
    chk("R1 chr", 64'(chr_s), pkc(0, 4));
    chk("R1 mirror", 64'(mir_s), 64'd3);
  endtask

  task automatic t_mode_low_switch;
    load(2'd0, 5'h0E);
    chk("R3 R7 prg", 64'(prg_s), pk4(0, 1, 30, 31, PW));
    chk("R5 mirror", 64'(mir_s), 64'd1);
    load(2'd3, 5'h15);
    chk("R7 prg", 64'(prg_s), pk4(10, 11, 30, 31, PW));
    chk("R4 prg big", 64'(prg_b), pk4(10, 11, 62, 63, PWB));
  endtask

  task automatic t_mode_32k;
    load(2'd0, 5'h02);
    chk("R6 prg", 64'(prg_s), pk4(20, 21, 22, 23, PW));
    chk("R5 mirror", 64'(mir_s), 64'd1);
  endtask

  task automatic t_mode_high_switch;
    load(2'd0, 5'h0B);
    chk("R8 prg", 64'(prg_s), pk4(0, 1, 10, 11, PW));
    chk("R5 mirror", 64'(mir_s), 64'd0);
  endtask

  task automatic t_wrap;
    load(2'd3, 5'h1F);
    load(2'd0, 5'h00);
    chk("R11 prg", 64'(prg_s), pk4(28, 29, 30, 31, PW));
    chk("R11 prg big", 64'(prg_b), pk4(60, 61, 62, 63, PWB));
  endtask

  task automatic t_chr_modes;
    load(2'd1, 5'h07);
    load(2'd2, 5'h1F);
    load(2'd0, 5'h10);
    chk("R9 chr", 64'(chr_s), pkc(28, 124));
    load(2'd0, 5'h00);
    chk("R10 chr", 64'(chr_s), pkc(24, 28));
  endtask

  task automatic t_clear;
    for (int i = 0; i < 3; i++) wr(2'd0, 1'b0, 1'b1);
    wr(2'd0, 1'b1, 1'b0);
    @(negedge clk);
    chk("R2 no update prg", 64'(prg_s), pk4(28, 29, 30, 31, PW));
    chk("R2 no update chr", 64'(chr_s), pkc(24, 28));
    load(2'd3, 5'h03);
    chk("R2 prg", 64'(prg_s), pk4(6, 7, 30, 31, PW));
    chk("R2 mirror", 64'(mir_s), 64'd3);
  endtask

  task automatic t_timing;
    for (int i = 0; i < 5; i++) wr(2'd3, 1'b0, (i == 0));
    chk("R13 before update", 64'(prg_s), pk4(6, 7, 30, 31, PW));
    @(negedge clk);
    chk("R13 after update", 64'(prg_s), pk4(2, 3, 30, 31, PW));
  endtask

  task automatic t_half_select;
    load(2'd1, 5'h10);
    chk("R12 prg big", 64'(prg_b), pk4(34, 35, 62, 63, PWB));
    chk("R12 prg small", 64'(prg_s), pk4(2, 3, 30, 31, PW));
    chk("R10 chr", 64'(chr_s), pkc(64, 68));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mode_low_switch();
    t_mode_32k();
    t_mode_high_switch();
    t_wrap();
    t_chr_modes();
    t_clear();
    t_timing();
    t_half_select();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule